// File: doc/BRIEF.md
# Slotted DMA Receive Writer

This block takes a continuous stream of complex baseband samples from a radio converter interface and writes them into a ring of fixed-size slots in host memory. Each slot starts with a header cache line that holds a descriptor word, followed by a payload area that is a whole number of 128-byte write bursts. Incoming samples wait in an on-chip FIFO. A payload burst starts only when a full burst's worth of samples is buffered, so every memory write sequence is 32 back-to-back word beats.

When the last payload beat of a slot has gone out, the block writes the slot's descriptor. The descriptor carries a valid flag and a running sequence number. The slot then belongs to the consumer until the consumer returns it through a clear strobe that names the slot index. Slots are filled in strict circular order. If the next slot in order has not been returned, the writer waits for it. While it waits, the FIFO fills. A sample that arrives while the FIFO is full is dropped, and a sticky overflow indication is raised.

Memory is addressed in 32-bit words. Slot `s` starts at word `s*SLOT_WORDS`, where `SLOT_WORDS = 16 + PAYLOAD_BURSTS*32`. The default is 80 words, made of one 16-word header line and two 32-word bursts.

Top module: `rx_slot_writer`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `wr_en` and `overflow` are low.
- R2: Payload word k (0-based, in arrival order) of slot s is written to address `s*SLOT_WORDS + 16 + k`, with data `{I, Q}`: I in bits 31:16 and Q in bits 15:0. No write touches header words 1 to 15 of a slot.
- R3: No memory write starts until at least 32 samples are buffered for the current burst. With only 31 samples delivered after reset, `wr_en` stays low.
- R4: The descriptor of a slot is written to word 0 of that slot. It is written only after all `PAYLOAD_BURSTS*32` payload words of that slot have been written.
- R5: The descriptor word has bit 0 = 1, bits 15:1 = 0, and bits 31:16 = a sequence number. The sequence number is 0 for the first slot published after reset and rises by one with each published slot, modulo 2^SEQ_W.
- R6: Slots are filled in the order 0, 1, ..., NUM_SLOTS-1, 0, ... Returning a slot other than the next one in order does not let the writer proceed.
- R7: A published slot is not written again until the consumer has returned it. While the next slot is held, no memory write occurs.
- R8: A sample presented while the FIFO holds FIFO_DEPTH samples is discarded and never written. `overflow` then goes high and stays high until reset. No overflow occurs while there is room.
- R9: A one-cycle `clr_en` pulse with `clr_idx` = s returns slot s. A writer stalled on slot s then fills it with buffered samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe, one sample per cycle when high |
| smp_i | input | 16 | In-phase part of the sample |
| smp_q | input | 16 | Quadrature part of the sample |
| clr_en | input | 1 | Consumer returns a slot |
| clr_idx | input | IDX_W (2) | Index of the returned slot |
| wr_en | output | 1 | Memory write strobe, one word per cycle |
| wr_addr | output | ADDR_W (9) | Word address of the write |
| wr_data | output | 32 | Write data: a payload sample or a descriptor |
| overflow | output | 1 | Sticky: a sample was dropped |

## Verification
The hardest condition to reach is a ring in which every slot is owned by the consumer while samples keep arriving. Only then does the writer stall, the FIFO fill to its exact depth, and a sample get dropped. The bench streams enough samples to publish every slot and withholds all returns. It then sends exactly FIFO_DEPTH more samples, which must not overflow, and one more sample, which must overflow. Next it returns an out-of-order slot, which must not release the writer, and then the slot the writer waits on. Returning a further slot and sending fresh samples shows from the memory image that the dropped sample never reached memory.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [1:0] {
    S_WAIT_SLOT,
    S_WAIT_DATA,
    S_BURST,
    S_DESC
  } wr_state_t;

  localparam int WORD_BYTES = 4;
  localparam int HALF_W     = 16;
  localparam int WORD_W     = 2 * HALF_W;
endpackage

// File: rtl/rxw_fifo.sv
module rxw_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr;
  logic [PTR_W-1:0] rptr;
  logic             push_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign push_ok = push && !full;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (pop) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop)     rptr <= rptr + 1'b1;
      count <= count + CNT_W'(push_ok) - CNT_W'(pop);
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));  // R3
endmodule

// File: rtl/rxw_slot_flags.sv
module rxw_slot_flags #(
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_en,
  input  logic [IDX_W-1:0]     set_idx,
  input  logic                 clr_en,
  input  logic [IDX_W-1:0]     clr_idx,
  output logic [NUM_SLOTS-1:0] busy
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                                       busy[i] <= 1'b0;
      else if (set_en && (set_idx == IDX_W'(i)))     busy[i] <= 1'b1;
      else if (clr_en && (clr_idx == IDX_W'(i)))     busy[i] <= 1'b0;
    end
  end

  AST_PUBLISH_FREE_SLOT: assert property (@(posedge clk) disable iff (rst)
    set_en |-> !busy[set_idx]);  // R7
endmodule

// File: rtl/rxw_burst_engine.sv
module rxw_burst_engine
  import rxw_pkg::*;
#(
  parameter int NUM_SLOTS      = 4,
  parameter int PAYLOAD_BURSTS = 2,
  parameter int BURST_WORDS    = 32,
  parameter int LINE_WORDS     = 16,
  parameter int SEQ_W          = 16,
  parameter int IDX_W          = 2,
  parameter int ADDR_W         = 9,
  parameter int CNT_W          = 7,
  localparam int PAYLOAD_WORDS = PAYLOAD_BURSTS * BURST_WORDS,
  localparam int SLOT_WORDS    = LINE_WORDS + PAYLOAD_WORDS,
  localparam int OFF_W         = $clog2(PAYLOAD_WORDS),
  localparam int BW_LOG        = $clog2(BURST_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CNT_W-1:0]     fifo_count,
  input  logic [NUM_SLOTS-1:0] busy,
  output logic                 pop,
  output logic                 set_en,
  output logic [IDX_W-1:0]     set_idx,
  output logic                 beat_v,
  output logic                 desc_v,
  output logic [ADDR_W-1:0]    stage_addr,
  output logic [WORD_W-1:0]    desc_word
);
  wr_state_t         state;
  logic [IDX_W-1:0]  slot;
  logic [ADDR_W-1:0] base;
  logic [OFF_W-1:0]  off;
  logic [SEQ_W-1:0]  seq;

  assign pop     = (state == S_BURST);
  assign set_en  = (state == S_DESC);
  assign set_idx = slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_WAIT_SLOT;
      slot   <= '0;
      base   <= '0;
      off    <= '0;
      seq    <= '0;
      beat_v <= 1'b0;
      desc_v <= 1'b0;
    end else begin
      beat_v <= 1'b0;
      desc_v <= 1'b0;
      case (state)
        S_WAIT_SLOT: if (!busy[slot]) state <= S_WAIT_DATA;
        S_WAIT_DATA: if (int'(fifo_count) >= BURST_WORDS) state <= S_BURST;
        S_BURST: begin
          beat_v     <= 1'b1;
          stage_addr <= base + ADDR_W'(LINE_WORDS) + ADDR_W'(off);
          off        <= off + 1'b1;
          if (&off[BW_LOG-1:0]) begin
            if (off == OFF_W'(PAYLOAD_WORDS - 1)) begin
              off   <= '0;
              state <= S_DESC;
            end else begin
              state <= S_WAIT_DATA;
            end
          end
        end
        S_DESC: begin
          desc_v     <= 1'b1;
          stage_addr <= base;
          desc_word  <= {seq, {(WORD_W - SEQ_W - 1){1'b0}}, 1'b1};
          seq        <= seq + 1'b1;
          if (slot == IDX_W'(NUM_SLOTS - 1)) begin
            slot <= '0;
            base <= '0;
          end else begin
            slot <= slot + 1'b1;
            base <= base + ADDR_W'(SLOT_WORDS);
          end
          state <= S_WAIT_SLOT;
        end
        default: state <= S_WAIT_SLOT;
      endcase
    end
  end

  AST_POP_FREE_SLOT: assert property (@(posedge clk) disable iff (rst)
    pop |-> !busy[slot]);  // R7
  AST_DESC_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
    desc_v |-> $past(beat_v));  // R4
endmodule

// File: rtl/rx_slot_writer.sv
module rx_slot_writer
  import rxw_pkg::*;
#(
  parameter int NUM_SLOTS      = 4,
  parameter int PAYLOAD_BURSTS = 2,
  parameter int FIFO_DEPTH     = 64,
  parameter int SEQ_W          = 16,
  parameter int BURST_BYTES    = 128,
  parameter int LINE_BYTES     = 64,
  localparam int BURST_WORDS   = BURST_BYTES / WORD_BYTES,
  localparam int LINE_WORDS    = LINE_BYTES / WORD_BYTES,
  localparam int SLOT_WORDS    = LINE_WORDS + PAYLOAD_BURSTS * BURST_WORDS,
  localparam int ADDR_W        = $clog2(NUM_SLOTS * SLOT_WORDS),
  localparam int IDX_W         = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CNT_W         = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [HALF_W-1:0] smp_i,
  input  logic [HALF_W-1:0] smp_q,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              overflow
);
  logic [WORD_W-1:0]    fifo_dout;
  logic [CNT_W-1:0]     fifo_count;
  logic                 fifo_full;
  logic                 pop;
  logic                 set_en;
  logic [IDX_W-1:0]     set_idx;
  logic [NUM_SLOTS-1:0] busy;
  logic                 beat_v;
  logic                 desc_v;
  logic [ADDR_W-1:0]    stage_addr;
  logic [WORD_W-1:0]    desc_word;

  rxw_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .push(smp_valid), .din({smp_i, smp_q}),
    .pop(pop), .dout(fifo_dout), .count(fifo_count), .full(fifo_full)
  );

  rxw_slot_flags #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) flags_i (
    .clk(clk), .rst(rst), .set_en(set_en), .set_idx(set_idx),
    .clr_en(clr_en), .clr_idx(clr_idx), .busy(busy)
  );

  rxw_burst_engine #(
    .NUM_SLOTS(NUM_SLOTS), .PAYLOAD_BURSTS(PAYLOAD_BURSTS),
    .BURST_WORDS(BURST_WORDS), .LINE_WORDS(LINE_WORDS), .SEQ_W(SEQ_W),
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) engine_i (
    .clk(clk), .rst(rst), .fifo_count(fifo_count), .busy(busy),
    .pop(pop), .set_en(set_en), .set_idx(set_idx), .beat_v(beat_v),
    .desc_v(desc_v), .stage_addr(stage_addr), .desc_word(desc_word)
  );

  // single registered output stage for payload and descriptor writes
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en    <= 1'b0;
      overflow <= 1'b0;
    end else begin
      wr_en <= beat_v | desc_v;
      if (smp_valid && fifo_full) overflow <= 1'b1;
    end
    wr_addr <= stage_addr;
    wr_data <= desc_v ? desc_word : fifo_dout;
  end

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(overflow) |-> overflow);  // R8
  AST_ONE_WRITE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !(beat_v && desc_v));  // R4
endmodule

// File: tb/rx_slot_writer_tb_top.sv
`timescale 1ns/1ps
module rx_slot_writer_tb_top;
  localparam int NUM_SLOTS  = 4;
  localparam int SLOT_WORDS = 80;
  localparam int PAY_WORDS  = 64;
  localparam int HDR_WORDS  = 16;
  localparam int FIFO_DEPTH = 64;
  localparam int MEM_WORDS  = NUM_SLOTS * SLOT_WORDS;

  // rows: {slot[7:0], seq[7:0], first sample index[15:0]}
  localparam logic [31:0] SLOT_TAB [4] = '{
    {8'd0, 8'd0, 16'd0},
    {8'd1, 8'd1, 16'd64},
    {8'd2, 8'd2, 16'd128},
    {8'd3, 8'd3, 16'd192}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_i = '0;
  logic [15:0] smp_q = '0;
  logic        clr_en = 1'b0;
  logic [1:0]  clr_idx = '0;
  logic        wr_en;
  logic [8:0]  wr_addr;
  logic [31:0] wr_data;
  logic        overflow;

  int errors = 0;
  int checks = 0;
  int wr_count = 0;
  int desc_cnt = 0;
  int next_smp = 0;
  int pay_cnt [NUM_SLOTS];
  logic [31:0] mem [MEM_WORDS];

  always #5 clk = ~clk;

  rx_slot_writer dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .clr_en(clr_en), .clr_idx(clr_idx), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .overflow(overflow)
  );

  function automatic logic [31:0] smp_word(input int n);
    return {n[15:0], ~n[15:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model and ordering monitor
  initial for (int s = 0; s < NUM_SLOTS; s++) pay_cnt[s] = 0;
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      int s, o;
      s = int'(wr_addr) / SLOT_WORDS;
      o = int'(wr_addr) % SLOT_WORDS;
      mem[int'(wr_addr)] = wr_data;
      wr_count++;
      if (o == 0) begin
        desc_cnt++;
        chk("R4 payload beats before descriptor", pay_cnt[s], PAY_WORDS);
        pay_cnt[s] = 0;
      end else if (o >= HDR_WORDS) begin
        pay_cnt[s]++;
      end else begin
        chk("R2 header padding untouched", o, 0);
      end
    end
  end

  task automatic push_n(input int n);
    for (int k = 0; k < n; k++) begin
      smp_valid = 1'b1;
      smp_i = next_smp[15:0];
      smp_q = ~next_smp[15:0];
      next_smp++;
      @(negedge clk);
      smp_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_desc(input int n);
    int t = 0;
    while (desc_cnt < n && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk("R6 descriptor count reached", desc_cnt, n);
  endtask

  task automatic release_slot(input int s);
    clr_en = 1'b1;
    clr_idx = s[1:0];
    @(negedge clk);
    clr_en = 1'b0;
  endtask

  task automatic check_slot(input string req, input int s, input int seq, input int first);
    int bad = 0;
    int base = s * SLOT_WORDS;
    chk({req, " descriptor R5"}, mem[base], {seq[15:0], 15'b0, 1'b1});
    for (int k = 0; k < PAY_WORDS; k++)
      if (mem[base + HDR_WORDS + k] !== smp_word(first + k)) bad++;
    chk({req, " payload R2"}, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 wr_en in reset", wr_en, 0);
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 wr_en after reset", wr_en, 0);
    chk("R1 overflow after reset", overflow, 0);

    // R3: one sample short of a burst
    push_n(31);
    idle(20);
    chk("R3 no write below one burst", wr_count, 0);

    // fill all slots of the ring
    push_n(NUM_SLOTS * PAY_WORDS - 31);
    wait_desc(NUM_SLOTS);
    idle(5);
    for (int r = 0; r < 4; r++)
      check_slot("R6 ring order", int'(SLOT_TAB[r][31:24]),
                 int'(SLOT_TAB[r][23:16]), int'(SLOT_TAB[r][15:0]));
    chk("R8 no overflow with room", overflow, 0);

    // all slots held: writer stalls, FIFO fills exactly
    push_n(FIFO_DEPTH);
    idle(40);
    chk("R7 no write while slot held", wr_count, NUM_SLOTS * (PAY_WORDS + 1));
    chk("R8 no overflow at exact depth", overflow, 0);
    push_n(1);  // sample 320 is dropped
    chk("R8 overflow on full FIFO", overflow, 1);

    // returning an out-of-order slot does not release the writer
    release_slot(2);
    idle(40);
    chk("R6 out-of-order return ignored", wr_count, NUM_SLOTS * (PAY_WORDS + 1));

    // return slot 0: wrap with sequence 4
    release_slot(0);
    wait_desc(NUM_SLOTS + 1);
    idle(5);
    check_slot("R9 released slot refilled", 0, 4, 256);
    chk("R8 overflow sticky", overflow, 1);

    // slot 1: fresh samples follow, dropped sample absent
    release_slot(1);
    push_n(PAY_WORDS);
    wait_desc(NUM_SLOTS + 2);
    idle(5);
    check_slot("R8 dropped sample never written", 1, 5, 321);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule